// File: doc/BRIEF.md
# Autonegotiation Result Validator

This block sits beside an Ethernet link manager and decides whether a finished autonegotiation can be trusted. A transceiver can claim that negotiation is done while its link-partner ability word is wrong. The block catches two kinds of this false completion. In the first kind, the partner is known to negotiate but its acknowledge never arrived. In the second kind, a low-power status flag was left clear when negotiation finished. When the result is suspect, the block requests a renegotiation instead of letting status decoding use bad data.

A check runs once for each rising of the done flag, and only while autonegotiation is enabled. A good result gives a one-cycle status-valid pulse and clears the count of consecutive failures. A bad result gives a one-cycle restart request. A bounded number of restarts is allowed. On the failure after the last allowed restart, the block raises a sticky error flag and stops requesting restarts. Turning autonegotiation off, or a reset, clears the error and the count. While autonegotiation is off, status passes through unchecked.

All inputs are levels sampled on the clock. All outputs are registered, so each output answers the inputs of the previous cycle. The ports carry only control and status levels, so there is no valid/ready stream at the edge and nothing can be back-pressured.

Top module: `an_validator`

## Requirements
- R1: Directly after reset, `restart_req`, `status_ok` and `give_up` are all 0.
- R2: While `an_enable` is 0, `status_ok` is 1 in the cycle after each such cycle, and `restart_req` stays 0 whatever the other inputs do.
- R3: While `an_done` is 0, no check is made: `restart_req` and `status_ok` stay 0 with `an_enable` at 1.
- R4: Late failure: at a check, bit 12 of `lpi_word` is 0. This gives a `restart_req` pulse one cycle long in the next cycle.
- R5: Early failure: at a check, bit 0 of `exp_word` is 1 and bit 14 of `lpa_word` is 0 (for example `lpa_word` = 0x0001). This gives a one-cycle `restart_req` pulse.
- R6: When bit 0 of `exp_word` is 0, a clear bit 14 of `lpa_word` is not a failure. With bit 12 of `lpi_word` set, the check passes.
- R7: A passing check gives a `status_ok` pulse one cycle long in the next cycle, with no `restart_req`.
- R8: Only one check is made for each rising of `an_done`. While `an_done` stays high afterwards, no further pulse appears until `an_done` falls and rises again.
- R9: Failures 1 to 6 in a row (MAX_RETRIES = 6) each request a restart. The seventh raises `give_up` instead. `give_up` then stays high and blocks every further restart and pulse while `an_enable` is 1.
- R10: One cycle with `an_enable` at 0 clears `give_up` and the failure count.
- R11: A passing check clears the failure count, so six new failures in a row each request a restart again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| an_enable | input | 1 | Autonegotiation enabled |
| an_done | input | 1 | Autonegotiation reported complete |
| lpa_word | input | 16 | Link-partner ability word; bit 14 is the acknowledge |
| exp_word | input | 16 | Expansion word; bit 0 means the partner can negotiate |
| lpi_word | input | 16 | Low-power status word; bit 12 must be set at completion |
| restart_req | output | 1 | One-cycle request to restart negotiation |
| status_ok | output | 1 | Status may be decoded (pulse on a pass, level while disabled) |
| give_up | output | 1 | Sticky error after retries are used up |

## Verification
A bad failure count shows up as `give_up` one check too early or too late, at the seventh failure or at the sixth or eighth. So the bench counts restarts across whole runs of failures, both before and after a pass. If the per-done arming state is corrupt, the effect appears within a cycle or two of holding `an_done` high: either repeated pulses or a check that never happens. A wrong failure decode flips `restart_req` against `status_ok` in the cycle right after the check.

// File: rtl/an_chk_pkg.sv
package an_chk_pkg;
  localparam int WORD_W       = 16;
  localparam int LPI_OK_BIT   = 12;
  localparam int EXP_NWAY_BIT = 0;
  localparam int LPA_ACK_BIT  = 14;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_WAIT_LO = 2'd1,
    ST_GAVE_UP = 2'd2
  } val_state_t;

  typedef struct packed {
    logic early;
    logic late;
  } fault_t;
endpackage

// File: rtl/an_fault_detect.sv
module an_fault_detect
  import an_chk_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] lpa_word,
  input  logic [W-1:0] exp_word,
  input  logic [W-1:0] lpi_word,
  output fault_t       fault,
  output logic         any_fault
);
  always_comb begin
    fault.late  = ~lpi_word[LPI_OK_BIT];
    fault.early = exp_word[EXP_NWAY_BIT] & ~lpa_word[LPA_ACK_BIT];
    any_fault   = fault.late | fault.early;
  end
endmodule

// File: rtl/an_retry_ctr.sv
module an_retry_ctr #(
  parameter int LIMIT = 6,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      cnt <= '0;
    else if (inc && !at_limit)
      cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(LIMIT));
endmodule

// File: rtl/an_validator.sv
module an_validator
  import an_chk_pkg::*;
#(
  parameter int MAX_RETRIES = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              an_enable,
  input  logic              an_done,
  input  logic [WORD_W-1:0] lpa_word,
  input  logic [WORD_W-1:0] exp_word,
  input  logic [WORD_W-1:0] lpi_word,
  output logic              restart_req,
  output logic              status_ok,
  output logic              give_up
);
  val_state_t state, state_nx;
  fault_t     fault;
  logic       bad, at_limit, check, pass, fail;

  an_fault_detect #(.W(WORD_W)) u_detect (
    .lpa_word (lpa_word),
    .exp_word (exp_word),
    .lpi_word (lpi_word),
    .fault    (fault),
    .any_fault(bad)
  );

  assign check = an_enable && an_done && (state == ST_ARMED);
  assign pass  = check && !bad;
  assign fail  = check && bad;

  an_retry_ctr #(.LIMIT(MAX_RETRIES)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!an_enable || pass),
    .inc     (fail),
    .at_limit(at_limit)
  );

  always_comb begin
    state_nx = state;
    if (!an_enable)
      state_nx = ST_ARMED;
    else begin
      unique case (state)
        ST_ARMED:   if (an_done) state_nx = (fail && at_limit) ? ST_GAVE_UP : ST_WAIT_LO;
        ST_WAIT_LO: if (!an_done) state_nx = ST_ARMED;
        default:    state_nx = ST_GAVE_UP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_ARMED;
      restart_req <= 1'b0;
      status_ok   <= 1'b0;
    end else begin
      state       <= state_nx;
      restart_req <= fail && !at_limit;
      status_ok   <= !an_enable || pass;
    end
  end

  assign give_up = (state == ST_GAVE_UP);

  logic unused_fault;
  assign unused_fault = fault.early ^ fault.late;
endmodule

// File: rtl/an_validator_chk.sv
module an_validator_chk (
  input logic clk,
  input logic rst_n,
  input logic an_enable,
  input logic an_done,
  input logic restart_req,
  input logic status_ok,
  input logic give_up
);
  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart_req && status_ok));
  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req);
  assert_done_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> $past(an_done && an_enable));
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |-> !restart_req);
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (give_up && an_enable) |=> give_up);
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !an_enable |=> !give_up);
  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !an_enable |=> status_ok);
endmodule

bind an_validator an_validator_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .an_enable  (an_enable),
  .an_done    (an_done),
  .restart_req(restart_req),
  .status_ok  (status_ok),
  .give_up    (give_up)
);

// File: tb/an_validator_bench.sv
module an_validator_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, an_enable, an_done;
  logic [15:0] lpa_word, exp_word, lpi_word;
  logic restart_req, status_ok, give_up;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  an_validator u_an_validator (
    .clk(clk), .rst_n(rst_n), .an_enable(an_enable), .an_done(an_done),
    .lpa_word(lpa_word), .exp_word(exp_word), .lpi_word(lpi_word),
    .restart_req(restart_req), .status_ok(status_ok), .give_up(give_up)
  );

  // {lpa, exp, lpi, expect restart, expect ok}
  localparam logic [49:0] VEC [0:5] = '{
    {16'h45E1, 16'h0001, 16'h1000, 1'b0, 1'b1},
    {16'h0001, 16'h0001, 16'h1000, 1'b1, 1'b0},
    {16'hC5E1, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {16'h0001, 16'h0000, 16'h1000, 1'b0, 1'b1},
    {16'h4001, 16'h0003, 16'hEFFF, 1'b1, 1'b0},
    {16'h41E1, 16'h0001, 16'h1000, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // drop done for one edge, then present words with done high; sample after the check edge
  task automatic run_check(input logic [15:0] l, input logic [15:0] e, input logic [15:0] p);
    an_done = 1'b0;
    @(negedge clk);
    lpa_word = l; exp_word = e; lpi_word = p; an_done = 1'b1;
    @(negedge clk);
  endtask

  task automatic fail_once(input string req, input logic exp_rst, input logic exp_gu);
    run_check(16'h0001, 16'h0001, 16'h1000);
    chk(req, "restart_req", restart_req, exp_rst);
    chk(req, "give_up", give_up, exp_gu);
  endtask

  initial begin
    rst_n = 1'b0; an_enable = 1'b1; an_done = 1'b0;
    lpa_word = '0; exp_word = '0; lpi_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "restart_req", restart_req, 1'b0);
    chk("R1", "status_ok", status_ok, 1'b0);
    chk("R1", "give_up", give_up, 1'b0);

    for (int i = 0; i < 6; i++) begin
      run_check(VEC[i][49:34], VEC[i][33:18], VEC[i][17:2]);
      chk("R4/R5/R6/R7 table", "restart_req", restart_req, VEC[i][1]);
      chk("R4/R5/R6/R7 table", "status_ok", status_ok, VEC[i][0]);
      @(negedge clk);
      chk("R4 R7 pulse width", "restart_req", restart_req, 1'b0);
      chk("R4 R7 pulse width", "status_ok", status_ok, 1'b0);
    end

    // R3: failing words with done low cause nothing
    an_done = 1'b0; lpa_word = 16'h0001; exp_word = 16'h0001; lpi_word = 16'h0000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R3", "restart_req", restart_req, 1'b0);
      chk("R3", "status_ok", status_ok, 1'b0);
    end

    // R8: done held high gives a single check
    run_check(16'h0001, 16'h0001, 16'h1000);
    chk("R8", "first restart", restart_req, 1'b1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R8", "no repeat", restart_req, 1'b0);
    end
    // one failure already counted; pass to clear
    run_check(16'h45E1, 16'h0001, 16'h1000);
    chk("R7", "status_ok", status_ok, 1'b1);

    // R9: six restarts then give up
    for (int k = 0; k < 6; k++) fail_once("R9", 1'b1, 1'b0);
    fail_once("R9 seventh", 1'b0, 1'b1);
    run_check(16'h45E1, 16'h0001, 16'h1000);
    chk("R9 blocked", "status_ok", status_ok, 1'b0);
    chk("R9 sticky", "give_up", give_up, 1'b1);
    fail_once("R9 blocked", 1'b0, 1'b1);

    // R10 / R2: disabling clears and passes through
    an_enable = 1'b0;
    @(negedge clk);
    chk("R10", "give_up", give_up, 1'b0);
    chk("R2", "status_ok", status_ok, 1'b1);
    run_check(16'h0001, 16'h0001, 16'h0000);
    chk("R2", "restart_req", restart_req, 1'b0);
    chk("R2", "status_ok", status_ok, 1'b1);
    an_enable = 1'b1;

    // R10 count cleared, R11 pass clears count mid-run
    for (int k = 0; k < 5; k++) fail_once("R10", 1'b1, 1'b0);
    run_check(16'h45E1, 16'h0001, 16'h1000);
    chk("R11", "status_ok", status_ok, 1'b1);
    for (int k = 0; k < 6; k++) fail_once("R11", 1'b1, 1'b0);
    fail_once("R11 seventh", 1'b0, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule